// File: doc/BRIEF.md
# Memory-Mapped 16-Pin GPIO Port Controller

This block is one general-purpose I/O port of sixteen pins, configured through a small register file on a simple word-addressed bus. Software selects which pins belong to the port function, which pins have their input path enabled, and the direction of each pin. It also sets the output levels through a plain data register or through atomic write-one-to-set and write-one-to-clear aliases. Direction has no directly writable register. It changes only through its own set and clear aliases. A 32-bit mux word is stored for a neighbouring pin-routing block.

Each access completes in a single cycle. The access size is checked against the register addressed: the mux word takes 4-byte accesses and every other location takes 2-byte accesses. A wrong size is reported in preference to an unmapped offset. A rejected access changes nothing.

Output levels are pushed to the pins after any write that can move data, and only on pins whose input path is disabled. Each such push is marked by a one-cycle valid pulse per pin. A level arriving on a pin is captured only when that pin is an input, its input path is enabled and it belongs to the port function.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `pinOut`, `pinOutValid`, `pinSampled`, `busRdata` and `busErr` are 0.
- R2: The mux word (offset 0x1C) accepts only 4-byte accesses (`busSize4`=1). Every other offset accepts only 2-byte accesses (`busSize4`=0). A wrong-size access raises `busErr` with `busErrKind`=1 in the same cycle and changes no state.
- R3: A correctly sized access to an offset with `busAddr[1:0]`≠0 or `busAddr`≥0x20 raises `busErr` with `busErrKind`=0 and changes no state. A 4-byte access to such an offset reports `busErrKind`=1, because the size check wins.
- R4: Writes to function enable (0x00), data (0x04) and input enable (0x18) store `busWdata[15:0]`. A write to the mux word (0x1C) stores all 32 bits. Each reads back the stored value, zero-extended.
- R5: A write to 0x08 ORs the written bits into data. A write to 0x0C clears the data bits written as 1. Reads of 0x04, 0x08 and 0x0C all return the data register.
- R6: Direction (1 = output) changes only through writes to 0x10, which sets the bits written as 1, and 0x14, which clears the bits written as 1. Reads of either offset return the direction value.
- R7: After a write to 0x04, 0x08, 0x0C or 0x10, on the next cycle each pin whose input-enable bit is 0 shows the new data bit on `pinOut` and pulses `pinOutValid` for one cycle. Pins whose input-enable bit is 1 keep their `pinOut` value.
- R8: Writes to 0x00, 0x14, 0x18 and 0x1C leave `pinOut` unchanged and `pinOutValid` at 0.
- R9: On each clock, `pinSampled[i]` takes `pinIn[i]` only if, at that edge, direction[i]=0, input-enable[i]=1 and function-enable[i]=1. Otherwise the bit holds its value.
- R10: Read data appears on `busRdata` in the cycle after the read and holds until the next read. A read that raises an error returns 0. When `busRd` and `busWr` are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busAddr | input | 6 | Byte offset of the access |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busSize4 | input | 1 | 1 = 4-byte access, 0 = 2-byte access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | Access rejected, same cycle |
| busErrKind | output | 1 | 1 = size error, 0 = unmapped offset |
| pinIn | input | 16 | Pin input levels |
| pinOut | output | 16 | Pin output levels |
| pinOutValid | output | 16 | Per-pin pulse on output refresh |
| pinSampled | output | 16 | Accepted input levels |

## Verification
Input capture and a configuration write can fall in the same cycle. When they do, the capture gate uses the direction, input-enable and function-enable values held before that write. The bench writes direction-set for a pin in the same cycle as it raises that pin's input. It expects the level to be accepted on that edge and a later change to be ignored. A table of register accesses covers size and offset errors and alias behaviour, and directed sequences cover output refresh masking and each of the three capture gates.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int RegIdxW = 3;

  typedef enum logic [RegIdxW-1:0] {
    REG_FUNC   = 3'd0,
    REG_DATA   = 3'd1,
    REG_DSET   = 3'd2,
    REG_DCLR   = 3'd3,
    REG_DIRSET = 3'd4,
    REG_DIRCLR = 3'd5,
    REG_INEN   = 3'd6,
    REG_MUX    = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic     wrFunc;
    logic     wrData;
    logic     wrSet;
    logic     wrClr;
    logic     wrDirSet;
    logic     wrDirClr;
    logic     wrInen;
    logic     wrMux;
    logic     rdEn;
    logic     rdZero;
    reg_idx_e rdSel;
  } port_strobe_t;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busSize4,
  output port_strobe_t      strb,
  output logic              busErr,
  output logic              busErrKind
);

  localparam int NumRegs = 1 << RegIdxW;

  logic         access;
  logic         rdReq;
  logic         aligned;
  logic         inRange;
  logic         muxOffset;
  logic         sizeBad;
  logic         errSize;
  logic         errMap;
  logic         accessOk;
  reg_idx_e     regIdx;
  logic [NumRegs-1:0] wrHit;

  assign access  = busRd | busWr;
  assign rdReq   = busRd & ~busWr;
  assign regIdx  = reg_idx_e'(busAddr[RegIdxW+1:2]);
  assign aligned = (busAddr[1:0] == 2'b00);

  generate
    if (ADDR_W > RegIdxW + 2) begin : g_upper
      assign inRange = (busAddr[ADDR_W-1:RegIdxW+2] == '0);
    end else begin : g_noUpper
      assign inRange = 1'b1;
    end
  endgenerate

  assign muxOffset = aligned & inRange & (regIdx == REG_MUX);
  assign sizeBad   = muxOffset ? ~busSize4 : busSize4;
  assign errSize   = access & sizeBad;
  assign errMap    = access & ~sizeBad & ~(aligned & inRange);
  assign accessOk  = access & ~errSize & ~errMap;

  assign busErr     = errSize | errMap;
  assign busErrKind = errSize;

  always_comb begin
    wrHit = '0;
    if (accessOk && busWr) wrHit[regIdx] = 1'b1;
  end

  always_comb begin
    strb          = '0;
    strb.wrFunc   = wrHit[REG_FUNC];
    strb.wrData   = wrHit[REG_DATA];
    strb.wrSet    = wrHit[REG_DSET];
    strb.wrClr    = wrHit[REG_DCLR];
    strb.wrDirSet = wrHit[REG_DIRSET];
    strb.wrDirClr = wrHit[REG_DIRCLR];
    strb.wrInen   = wrHit[REG_INEN];
    strb.wrMux    = wrHit[REG_MUX];
    strb.rdEn     = rdReq & accessOk;
    strb.rdZero   = rdReq & ~accessOk;
    strb.rdSel    = regIdx;
  end

  // R4: at most one register is written per access
  assert_wr_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrFunc, strb.wrData, strb.wrSet, strb.wrClr,
              strb.wrDirSet, strb.wrDirClr, strb.wrInen, strb.wrMux}));

  // R2: a rejected access produces no write strobe
  assert_err_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busErr |-> !(strb.wrFunc | strb.wrData | strb.wrSet | strb.wrClr |
                 strb.wrDirSet | strb.wrDirClr | strb.wrInen | strb.wrMux));

  // R10: a write and a read are never both carried out in one cycle
  assert_wr_beats_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busWr |-> !strb.rdEn);

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PINS  = 16,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  port_strobe_t     strb,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic [PINS-1:0]  pinIn,
  output logic [PINS-1:0]  pinOut,
  output logic [PINS-1:0]  pinOutValid,
  output logic [PINS-1:0]  pinSampled
);

  logic [PINS-1:0]  funcEn;
  logic [PINS-1:0]  dataReg;
  logic [PINS-1:0]  dirReg;
  logic [PINS-1:0]  inEn;
  logic [BUS_W-1:0] muxWord;

  logic [PINS-1:0]  wrVal;
  logic [PINS-1:0]  dataNext;
  logic [PINS-1:0]  dirNext;
  logic             refresh;
  logic [BUS_W-1:0] rdMux;
  logic [PINS-1:0]  acceptPin;

  assign wrVal = busWdata[PINS-1:0];

  always_comb begin
    dataNext = dataReg;
    if (strb.wrData)     dataNext = wrVal;
    else if (strb.wrSet) dataNext = dataReg | wrVal;
    else if (strb.wrClr) dataNext = dataReg & ~wrVal;
  end

  always_comb begin
    dirNext = dirReg;
    if (strb.wrDirSet)      dirNext = dirReg | wrVal;
    else if (strb.wrDirClr) dirNext = dirReg & ~wrVal;
  end

  assign refresh = strb.wrData | strb.wrSet | strb.wrClr | strb.wrDirSet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      funcEn  <= '0;
      dataReg <= '0;
      dirReg  <= '0;
      inEn    <= '0;
      muxWord <= '0;
    end else begin
      dataReg <= dataNext;
      dirReg  <= dirNext;
      if (strb.wrFunc) funcEn  <= wrVal;
      if (strb.wrInen) inEn    <= wrVal;
      if (strb.wrMux)  muxWord <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinOut      <= '0;
      pinOutValid <= '0;
    end else begin
      pinOutValid <= refresh ? ~inEn : '0;
      if (refresh) pinOut <= (dataNext & ~inEn) | (pinOut & inEn);
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      REG_FUNC:                       rdMux = BUS_W'(funcEn);
      REG_DATA, REG_DSET, REG_DCLR:   rdMux = BUS_W'(dataReg);
      REG_DIRSET, REG_DIRCLR:         rdMux = BUS_W'(dirReg);
      REG_INEN:                       rdMux = BUS_W'(inEn);
      REG_MUX:                        rdMux = muxWord;
      default:                        rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busRdata <= '0;
    else if (strb.rdZero) busRdata <= '0;
    else if (strb.rdEn)   busRdata <= rdMux;
  end

  generate
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      assign acceptPin[p] = ~dirReg[p] & inEn[p] & funcEn[p];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pinSampled[p] <= 1'b0;
        else if (acceptPin[p]) pinSampled[p] <= pinIn[p];
      end

      // R9: a gated-off pin keeps its captured level
      assert_gated_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acceptPin[p] |=> $stable(pinSampled[p]));
    end
  endgenerate

  // R8: a direction-clear write never pushes outputs
  assert_dirclr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrDirClr |=> (pinOutValid == '0));

  // R10: a rejected read returns zero
  assert_rd_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdZero |=> (busRdata == '0));

  // R7: pins with input enabled are never marked as refreshed
  assert_refresh_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> ((pinOutValid & $past(inEn)) == '0));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int ADDR_W = 6,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busSize4,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              busErr,
  output logic              busErrKind,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOutValid,
  output logic [PINS-1:0]   pinSampled
);

  port_strobe_t strb;

  gpio_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .busAddr    (busAddr),
    .busRd      (busRd),
    .busWr      (busWr),
    .busSize4   (busSize4),
    .strb       (strb),
    .busErr     (busErr),
    .busErrKind (busErrKind)
  );

  gpio_port_regs #(.PINS(PINS), .BUS_W(BUS_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .pinIn       (pinIn),
    .pinOut      (pinOut),
    .pinOutValid (pinOutValid),
    .pinSampled  (pinSampled)
  );

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic        busSize4 = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic        busErrKind;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut;
  logic [15:0] pinOutValid;
  logic [15:0] pinSampled;

  int nChecks = 0;
  int nFails  = 0;
  logic doneFlag = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busSize4(busSize4), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .busErrKind(busErrKind), .pinIn(pinIn), .pinOut(pinOut),
    .pinOutValid(pinOutValid), .pinSampled(pinSampled)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic        sz4;
    logic [31:0] wd;
    logic        err;
    logic        kind;
    logic [31:0] rd;
  } vec_t;

  localparam int NVec = 27;
  localparam vec_t VECS [NVec] = '{
    '{1'b0, 6'h00, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0},        // R1
    '{1'b1, 6'h00, 1'b0, 32'h0000F0F0, 1'b0, 1'b0, 32'h0},        // R4
    '{1'b0, 6'h00, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0000F0F0}, // R4
    '{1'b1, 6'h04, 1'b0, 32'hFFFF1234, 1'b0, 1'b0, 32'h0},        // R4
    '{1'b0, 6'h04, 1'b0, 32'h0,        1'b0, 1'b0, 32'h00001234}, // R4
    '{1'b1, 6'h08, 1'b0, 32'h00008001, 1'b0, 1'b0, 32'h0},        // R5
    '{1'b0, 6'h0C, 1'b0, 32'h0,        1'b0, 1'b0, 32'h00009235}, // R5
    '{1'b1, 6'h0C, 1'b0, 32'h00000204, 1'b0, 1'b0, 32'h0},        // R5
    '{1'b0, 6'h08, 1'b0, 32'h0,        1'b0, 1'b0, 32'h00009031}, // R5
    '{1'b1, 6'h10, 1'b0, 32'h000000FF, 1'b0, 1'b0, 32'h0},        // R6
    '{1'b1, 6'h14, 1'b0, 32'h0000000F, 1'b0, 1'b0, 32'h0},        // R6
    '{1'b0, 6'h10, 1'b0, 32'h0,        1'b0, 1'b0, 32'h000000F0}, // R6
    '{1'b0, 6'h14, 1'b0, 32'h0,        1'b0, 1'b0, 32'h000000F0}, // R6
    '{1'b1, 6'h1C, 1'b1, 32'hDEADBEEF, 1'b0, 1'b0, 32'h0},        // R4
    '{1'b0, 6'h1C, 1'b1, 32'h0,        1'b0, 1'b0, 32'hDEADBEEF}, // R4
    '{1'b1, 6'h1C, 1'b0, 32'h12345678, 1'b1, 1'b1, 32'h0},        // R2
    '{1'b0, 6'h1C, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0},        // R2
    '{1'b0, 6'h1C, 1'b1, 32'h0,        1'b0, 1'b0, 32'hDEADBEEF}, // R2
    '{1'b1, 6'h04, 1'b1, 32'h0,        1'b1, 1'b1, 32'h0},        // R2
    '{1'b0, 6'h04, 1'b0, 32'h0,        1'b0, 1'b0, 32'h00009031}, // R2
    '{1'b1, 6'h02, 1'b0, 32'h0000FFFF, 1'b1, 1'b0, 32'h0},        // R3
    '{1'b1, 6'h20, 1'b0, 32'h0000FFFF, 1'b1, 1'b0, 32'h0},        // R3
    '{1'b0, 6'h24, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0},        // R3
    '{1'b0, 6'h22, 1'b1, 32'h0,        1'b1, 1'b1, 32'h0},        // R3
    '{1'b1, 6'h18, 1'b0, 32'h0000000F, 1'b0, 1'b0, 32'h0},        // R4
    '{1'b0, 6'h18, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0000000F}, // R4
    '{1'b0, 6'h04, 1'b0, 32'h0,        1'b0, 1'b0, 32'h00009031}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one access at a falling edge, captures the error flags mid-cycle,
  // then releases strobes at the next falling edge (registered results visible).
  task automatic access(input logic wr, input logic rd, input logic [5:0] a,
                        input logic sz4, input logic [31:0] wd,
                        output logic err, output logic kind);
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busSize4 = sz4; busWdata = wd;
    #1;
    err = busErr; kind = busErrKind;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [31:0] wd);
    logic e, k;
    access(1'b1, 1'b0, a, 1'b0, wd, e, k);
  endtask

  initial begin
    #(4 * 200000);
    if (!doneFlag) begin
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic e, k;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 pinOut", 32'(pinOut), 32'h0);
    chk("R1 pinOutValid", 32'(pinOutValid), 32'h0);
    chk("R1 pinSampled", 32'(pinSampled), 32'h0);
    chk("R1 busRdata", busRdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busErr", 32'(busErr), 32'h0);

    for (int i = 0; i < NVec; i++) begin
      access(VECS[i].wr, ~VECS[i].wr, VECS[i].addr, VECS[i].sz4, VECS[i].wd, e, k);
      chk($sformatf("R2/R3 err vec%0d", i), 32'(e), 32'(VECS[i].err));
      chk($sformatf("R2/R3 kind vec%0d", i), 32'(k), 32'(VECS[i].kind));
      if (!VECS[i].wr) chk($sformatf("R10 rdata vec%0d", i), busRdata, VECS[i].rd);
    end
    // R8: dir-clear, mux and error writes did not move outputs; last refresh was 0x9031
    chk("R8 pinOut after table", 32'(pinOut), 32'h9031);

    // R7: data write with inen=0x000F refreshes only pins 4..15
    access(1'b1, 1'b0, 6'h04, 1'b0, 32'h000000FF, e, k);
    chk("R7 pinOut masked", 32'(pinOut), 32'h00F1);
    chk("R7 pinOutValid pulse", 32'(pinOutValid), 32'hFFF0);
    @(negedge clk);
    chk("R7 pinOutValid one cycle", 32'(pinOutValid), 32'h0);

    // R8: dir-clear and input-enable writes do not refresh
    access(1'b1, 1'b0, 6'h14, 1'b0, 32'h000000F0, e, k);
    chk("R8 dirclr valid", 32'(pinOutValid), 32'h0);
    access(1'b1, 1'b0, 6'h18, 1'b0, 32'h00000000, e, k);
    chk("R8 inen valid", 32'(pinOutValid), 32'h0);
    chk("R8 pinOut held", 32'(pinOut), 32'h00F1);

    // R10: read data is registered and write wins over read
    busAddr = 6'h18; busSize4 = 1'b0; busRd = 1'b1;
    #1;
    chk("R10 rdata before edge", busRdata, 32'h00009031);
    @(negedge clk);
    busRd = 1'b0;
    chk("R10 rdata after edge", busRdata, 32'h0);
    access(1'b1, 1'b1, 6'h18, 1'b0, 32'h00000003, e, k);
    chk("R10 read suppressed by write", busRdata, 32'h0);

    // R9: capture gating, dir now 0
    wrReg(6'h00, 32'h0000FFFF);
    wrReg(6'h18, 32'h0000FFFF);
    pinIn = 16'hAAAA;
    repeat (2) @(negedge clk);
    chk("R9 all open", 32'(pinSampled), 32'hAAAA);
    wrReg(6'h10, 32'h0000000F);
    pinIn = 16'h5555;
    repeat (2) @(negedge clk);
    chk("R9 dir gate", 32'(pinSampled), 32'h555A);
    wrReg(6'h18, 32'h000000FF);
    pinIn = 16'hFFFF;
    repeat (2) @(negedge clk);
    chk("R9 inen gate", 32'(pinSampled), 32'h55FA);
    wrReg(6'h00, 32'h00000000);
    pinIn = 16'h0000;
    repeat (2) @(negedge clk);
    chk("R9 func gate", 32'(pinSampled), 32'h55FA);

    // R9: capture in the same cycle as a direction-set write uses old direction
    wrReg(6'h14, 32'h0000FFFF);
    wrReg(6'h00, 32'h0000FFFF);
    wrReg(6'h18, 32'h0000FFFF);
    repeat (2) @(negedge clk);
    chk("R9 settle zero", 32'(pinSampled), 32'h0);
    @(negedge clk);
    busWr = 1'b1; busAddr = 6'h10; busSize4 = 1'b0; busWdata = 32'h1;
    pinIn = 16'h0001;
    @(negedge clk);
    busWr = 1'b0;
    pinIn = 16'h0000;
    chk("R9 same-cycle accept", 32'(pinSampled), 32'h0001);
    repeat (2) @(negedge clk);
    chk("R9 later ignored", 32'(pinSampled), 32'h0001);

    doneFlag = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule